// File: doc/BRIEF.md
# Flash memory CRC scan controller

This block checks a region of program memory for corruption. It reads the region one 16-bit word at a time through a memory read port, folds every word except the last into a CRC-16, and then compares the result with the checksum held in the region's final word. A match raises a done flag. A mismatch raises a sticky error that drives a non-maskable interrupt output.

A one-byte control register selects the scan mode and the region, and a start strobe launches the scan. The scanner can run at high priority, where it holds the CPU in a halt until the scan ends. It can run in the background, where it uses the memory port only in cycles the CPU leaves free. In continuous mode it runs in the background and begins a new pass after every pass that matches. A reset-time initialization strobe can also launch a scan. The control register is locked while a scan runs and after an error.

Top module: `flash_crc_scanner`

## Requirements
- R1: After reset, cfg_rdata reads 0x00, and busy, done, nmi, cpu_halt and mem_req are all low.
- R2: The mode field is cfg_rdata[5:4] and the region field is cfg_rdata[1:0]. Both take their value from the same bits of cfg_wdata when cfg_we is high. Bits 7:6 and 3:2 always read zero.
- R3: A write to the control register is ignored, and cfg_rdata holds its value, while busy is high or after nmi has risen.
- R4: Mode 0 is priority mode. From the cycle after start until the scan ends, busy and cpu_halt are high, and mem_req is raised even while cpu_req is high.
- R5: Mode 2 is background mode. mem_req is never high in a cycle in which cpu_req is high, and cpu_halt stays low.
- R6: Region 0 covers TOTAL_WORDS words, region 1 covers APP_END_WORDS words and region 2 covers BOOT_WORDS words, all starting at address 0. One scan pass is granted each address once, in ascending order. mem_req is low whenever busy is low.
- R7: The CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF, fed most significant bit first. It covers words 0 to N-2, high byte first. When it equals word N-1, done goes high, nmi stays low and, in a single-pass mode, busy goes low.
- R8: Mode 3 is continuous mode. After a matching pass, done is high and busy stays high while a new pass starts at address 0.
- R9: On a mismatch, nmi goes high and stays high until reset, busy goes low and any continuous rescan stops. After that, start has no effect.
- R10: With a reserved mode (1) or a reserved region (3) stored, start is ignored and busy stays low.
- R11: An init_start pulse while idle starts a scan of the region given by init_src. From the next cycle cfg_rdata shows mode 2 and that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| start | input | 1 | Start a scan with the stored settings |
| init_start | input | 1 | Reset-time initialization start |
| init_src | input | 2 | Region for the initialization scan |
| cpu_req | input | 1 | CPU wants the memory port this cycle |
| mem_req | output | 1 | Scanner read request |
| mem_addr | output | AW | Word address of the read |
| mem_gnt | input | 1 | Read granted; data follows next cycle |
| mem_rdata | input | 16 | Read data, valid the cycle after a grant |
| cpu_halt | output | 1 | Halt request to the CPU |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last pass matched its checksum |
| nmi | output | 1 | Sticky checksum-mismatch error |

## Verification
The scanner's read request and a CPU request for the memory port can fall in the same cycle. The outcome depends on the mode: the scanner must win in priority mode and must step aside in background and continuous modes. The bench holds cpu_req high for the whole priority scan and drives it from a pseudo-random pattern during the background scans. A monitor counts every cycle in which mem_req and cpu_req are both high without a halt, and checks that each granted address follows the previous one. Each scenario then compares those counts, the number of grants and the done and nmi flags with the values that the region size and the stored checksum predict.

// File: rtl/flash_crc_scanner.sv
module flash_crc_scanner #(
  parameter int BOOT_WORDS    = 16,
  parameter int APP_END_WORDS = 40,
  parameter int TOTAL_WORDS   = 64,
  localparam int AW = $clog2(TOTAL_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          start,
  input  logic          init_start,
  input  logic [1:0]    init_src,
  input  logic          cpu_req,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic [15:0]   mem_rdata,
  output logic          cpu_halt,
  output logic          busy,
  output logic          done,
  output logic          nmi
);
  localparam logic [AW-1:0] LAST_BOOT = AW'(BOOT_WORDS - 1);
  localparam logic [AW-1:0] LAST_APP  = AW'(APP_END_WORDS - 1);
  localparam logic [AW-1:0] LAST_ALL  = AW'(TOTAL_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_DATA, S_HI, S_LO} state_t;

  state_t        state;
  logic [1:0]    mode, src;
  logic [15:0]   crc, wbuf;
  logic [AW-1:0] last;
  logic          err;

  wire unused_wdata = ^{cfg_wdata[7:6], cfg_wdata[3:2]};

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [AW-1:0] region_last(input logic [1:0] s);
    case (s)
      2'd1:    return LAST_APP;
      2'd2:    return LAST_BOOT;
      default: return LAST_ALL;
    endcase
  endfunction

  wire prio     = (mode == 2'd0);
  wire can_run  = (mode != 2'd1) && (src != 2'd3);

  assign busy      = (state != S_IDLE);
  assign nmi       = err;
  assign cpu_halt  = busy && prio;
  assign mem_req   = (state == S_REQ) && (prio || !cpu_req);
  assign cfg_rdata = {2'b00, mode, 2'b00, src};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode     <= 2'd0;
      src      <= 2'd0;
      crc      <= 16'hFFFF;
      wbuf     <= 16'h0000;
      last     <= '0;
      mem_addr <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (cfg_we && !busy && !err) begin
        mode <= cfg_wdata[5:4];
        src  <= cfg_wdata[1:0];
      end
      case (state)
        S_IDLE: begin
          if (!err && init_start && init_src != 2'd3) begin
            mode     <= 2'd2;
            src      <= init_src;
            last     <= region_last(init_src);
            mem_addr <= '0;
            crc      <= 16'hFFFF;
            done     <= 1'b0;
            state    <= S_REQ;
          end else if (!err && start && can_run) begin
            last     <= region_last(src);
            mem_addr <= '0;
            crc      <= 16'hFFFF;
            done     <= 1'b0;
            state    <= S_REQ;
          end
        end
        S_REQ: if (mem_req && mem_gnt) state <= S_DATA;
        S_DATA: begin
          wbuf <= mem_rdata;
          if (mem_addr == last) begin
            if (crc == mem_rdata) begin
              done <= 1'b1;
              if (mode == 2'd3) begin
                mem_addr <= '0;
                crc      <= 16'hFFFF;
                state    <= S_REQ;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              err   <= 1'b1;
              state <= S_IDLE;
            end
          end else begin
            state <= S_HI;
          end
        end
        S_HI: begin
          crc   <= crc_byte(crc, wbuf[15:8]);
          state <= S_LO;
        end
        S_LO: begin
          crc      <= crc_byte(crc, wbuf[7:0]);
          mem_addr <= mem_addr + 1'b1;
          state    <= S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_crc_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       cpu_req,
  input logic       mem_req,
  input logic       cpu_halt,
  input logic       busy,
  input logic       nmi
);
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || nmi) |=> $stable(cfg_rdata));
  assert_halt_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> busy);
  assert_yield_to_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_req) |-> cpu_halt);
  assert_no_req_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  assert_nmi_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> nmi);
  assert_nmi_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> !busy);
endmodule

bind flash_crc_scanner flash_crc_scanner_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .cpu_req(cpu_req),
  .mem_req(mem_req), .cpu_halt(cpu_halt), .busy(busy), .nmi(nmi)
);

// File: tb/flash_crc_scanner_tb_top.sv
`timescale 1ns/1ps
module flash_crc_scanner_tb_top;
  localparam int NB = 16, NA = 40, NT = 64, AW = $clog2(NT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0, init_start = 1'b0, cpu_req = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [1:0] init_src = 2'd0;
  logic [7:0] cfg_rdata;
  logic mem_req, mem_gnt, cpu_halt, busy, done, nmi;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = 16'h0000;
  logic [15:0] mem [NT];
  int checks = 0, errors = 0;
  int cpu_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int grants = 0, order_err = 0, conflicts = 0, halt_cyc = 0;
  logic [AW-1:0] prev_addr = '0;

  always #4 clk = ~clk;

  flash_crc_scanner #(.BOOT_WORDS(NB), .APP_END_WORDS(NA), .TOTAL_WORDS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start(start), .init_start(init_start), .init_src(init_src), .cpu_req(cpu_req),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .cpu_halt(cpu_halt), .busy(busy), .done(done), .nmi(nmi));

  assign mem_gnt = mem_req && (cpu_halt || !cpu_req);

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cpu_req <= (cpu_mode == 1) ? 1'b1 : (cpu_mode == 2) ? lfsr[3] : 1'b0;
    if (mem_req && mem_gnt) begin
      mem_rdata <= mem[mem_addr];
      if (!(mem_addr == '0 || mem_addr == prev_addr + 1'b1)) order_err <= order_err + 1;
      prev_addr <= mem_addr;
      grants <= grants + 1;
    end
    if (mem_req && cpu_req && !cpu_halt) conflicts <= conflicts + 1;
    if (cpu_halt) halt_cyc <= halt_cyc + 1;
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int w = 0; w < n - 1; w++)
      for (int k = 15; k >= 0; k--) begin
        logic fb;
        fb = c[15] ^ mem[w][k];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < NT; i++) mem[i] = 16'(i * 16'h03A7 + seed);
    mem[n-1] = ref_crc(n);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
    chk({busy, done, nmi, cpu_halt, mem_req} == 5'b0, "R1 flags",
        {busy, done, nmi, cpu_halt, mem_req}, 0);
  endtask

  task automatic t_fields;
    wr(8'hFF);
    chk(cfg_rdata == 8'h33, "R2 readback ff", cfg_rdata, 8'h33);
    wr(8'h12);
    chk(cfg_rdata == 8'h12, "R2 readback 12", cfg_rdata, 8'h12);
    pulse_start; @(negedge clk);
    chk(!busy && !mem_req, "R10 reserved mode", busy, 0);
    wr(8'h23);
    pulse_start; @(negedge clk);
    chk(!busy && !mem_req, "R10 reserved src", busy, 0);
  endtask

  task automatic t_priority;
    int g0, c0;
    fill(NT, 16'h1234);
    wr(8'h00);
    cpu_mode = 1;
    @(negedge clk); g0 = grants; c0 = conflicts;
    pulse_start;
    chk(busy && cpu_halt, "R4 halt", {busy, cpu_halt}, 3);
    repeat (3) @(negedge clk);
    chk(cpu_req && mem_req || !busy || grants > g0, "R4 wins over cpu", mem_req, 1);
    wr(8'h21);
    chk(cfg_rdata == 8'h00, "R3 locked busy", cfg_rdata, 0);
    wait_idle("R4 finish");
    chk(!cpu_halt, "R4 halt released", cpu_halt, 0);
    chk(grants - g0 == NT, "R6 whole region count", grants - g0, NT);
    chk(order_err == 0, "R6 order", order_err, 0);
    chk(done && !nmi, "R7 match whole", {done, nmi}, 2);
    cpu_mode = 0;
  endtask

  task automatic t_background(input logic [1:0] s, input int n);
    int g0, c0, h0;
    fill(n, 16'h0BEE + n);
    wr({2'b00, 2'd2, 2'b00, s});
    cpu_mode = 2;
    @(negedge clk); g0 = grants; c0 = conflicts; h0 = halt_cyc;
    pulse_start;
    chk(busy && !cpu_halt, "R5 no halt", {busy, cpu_halt}, 2);
    wait_idle("R5 finish");
    chk(conflicts == c0, "R5 yields", conflicts - c0, 0);
    chk(halt_cyc == h0, "R5 halt cycles", halt_cyc - h0, 0);
    chk(grants - g0 == n, "R6 region count", grants - g0, n);
    chk(order_err == 0, "R6 order bg", order_err, 0);
    chk(done && !nmi, "R7 match bg", {done, nmi}, 2);
    cpu_mode = 0;
  endtask

  task automatic t_continuous;
    int n = 0, g0, c0;
    fill(NB, 16'h5A5A);
    wr(8'h32);
    cpu_mode = 2;
    @(negedge clk); g0 = grants; c0 = conflicts;
    pulse_start;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done && busy, "R8 restart after match", {done, busy}, 3);
    repeat (20) @(negedge clk);
    chk(grants - g0 > NB, "R8 second pass", grants - g0, NB + 1);
    mem[3] = mem[3] ^ 16'h0100;
    wait_idle("R9 stops");
    chk(nmi, "R9 nmi set", nmi, 1);
    chk(conflicts == c0, "R5 yields cont", conflicts - c0, 0);
    g0 = grants;
    repeat (20) @(negedge clk);
    chk(grants == g0 && !mem_req, "R9 no rescan", grants - g0, 0);
    wr(8'h02);
    chk(cfg_rdata == 8'h32, "R3 locked nmi", cfg_rdata, 8'h32);
    pulse_start; @(negedge clk);
    chk(!busy && nmi, "R9 start ignored", busy, 0);
    cpu_mode = 0;
  endtask

  task automatic t_init;
    int g0;
    fill(NA, 16'h7777);
    @(negedge clk); g0 = grants;
    init_src = 2'd1; init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    chk(cfg_rdata == 8'h21, "R11 mode readback", cfg_rdata, 8'h21);
    chk(busy && !cpu_halt, "R11 running bg", {busy, cpu_halt}, 2);
    wait_idle("R11 finish");
    chk(grants - g0 == NA && done && !nmi, "R11 scan result", grants - g0, NA);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fields;
    do_reset;
    t_priority;
    t_background(2'd1, NA);
    t_background(2'd2, NB);
    t_continuous;
    do_reset;
    t_reset;
    t_init;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule